// File: doc/BRIEF.md
# Page-Mode Flash Read Controller

This block sits between a host that issues single-word read requests and a parallel NOR flash whose reads are asynchronous and timed. It accepts one word address at a time through a valid/ready handshake. It drives the flash address, chip enable and output enable, waits a programmed number of clock cycles, and then captures the flash data bus. The data comes back to the host with a one-cycle valid pulse.

The flash serves reads within one page faster once that page is open. A page is eight words: the three low address bits pick the word and the remaining upper bits name the page. The controller records which page is open. It keeps chip enable low between reads, so that a later read to the same page waits only the short page-access count. A read to another page, the first read after reset, and the first read after chip enable has been released all wait the long initial-access count. If no request arrives for a programmed number of idle cycles, the controller releases chip enable and forgets the open page. Write enable is never asserted. The flash is in read mode from power-up, so no command is sent.

Top module: `pgflash_rd_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, fl_ce_n and fl_oe_n are 1, rd_valid is 0 and req_ready is 1. Reset also clears the open-page record, so the next read is a miss.
- R2: A read that misses returns rd_valid exactly T_INIT cycles after the clock edge that accepted it. A miss is the first read after reset, a read to a page other than the open one, or a read after chip enable was released.
- R3: A read that hits returns rd_valid exactly T_PAGE cycles after its accepting edge. A hit is a read whose address bits above bit 2 equal those of the previous read while chip enable stayed low.
- R4: The page is the address with bits [2:0] removed. Changing only bits [2:0] keeps a hit; changing any higher bit is a miss.
- R5: After a read completes, fl_ce_n stays 0 and fl_oe_n returns to 1 while the controller waits for the next request.
- R6: After IDLE_TO consecutive idle clock edges with no request, fl_ce_n goes to 1 and the open page is forgotten. A request after IDLE_TO-1 idle edges is still a hit; a request after IDLE_TO idle edges is a miss.
- R7: rd_data equals the value on fl_dq at the edge that ends the wait for the accepted address, and rd_valid is high for exactly one cycle per read.
- R8: req_ready is 1 only while idle. A request presented during a wait is ignored and does not change the address or the returned data.
- R9: fl_we_n is always 1. fl_oe_n is 0 during every wait and is never 0 while fl_ce_n is 1.
- R10: fl_addr equals the accepted address and holds steady from acceptance until the read completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host read request |
| req_addr | input | ADDR_W | Word address of the request |
| req_ready | output | 1 | Controller idle; request accepted this cycle if valid |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds the read word |
| rd_data | output | DATA_W | Captured read word |
| fl_addr | output | ADDR_W | Flash word address |
| fl_dq | input | DATA_W | Flash data bus |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low, held high |

## Verification
The checker assumes the host changes req_valid and req_addr only between clock edges, and that reset is synchronous. It makes no assumption about fl_dq, because the properties cover only the sequencing of enables, address and valid pulses. The bench drives all inputs at the falling edge. Its flash model puts correct data on fl_dq only once chip enable, the page bits and the full address have each been steady for the required number of cycles; at any other time it drives the inverse. A capture that comes too early therefore shows up as wrong data as well as wrong latency. The sweeps cover every word of many pages in several orders, the idle gaps on both sides of the timeout, requests during a wait, and a reset between reads.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

    localparam int WORD_SEL_W = 3;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } rd_state_e;

    function automatic int access_cycles(input logic hit, input int t_init, input int t_page);
        return hit ? t_page : t_init;
    endfunction

endpackage

// File: rtl/pgf_page_track.sv
module pgf_page_track #(
    parameter int PG_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PG_W-1:0] req_page,
    input  logic            open_load,
    input  logic            open_drop,
    output logic            page_hit
);
    logic            open_q;
    logic [PG_W-1:0] page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            page_q <= '0;
        end else if (open_load) begin
            open_q <= 1'b1;
            page_q <= req_page;
        end else if (open_drop) begin
            open_q <= 1'b0;
        end
    end

    assign page_hit = open_q && (page_q == req_page);
endmodule

// File: rtl/pgf_wait_cnt.sv
module pgf_wait_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expired = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/pgf_idle_cnt.sv
module pgf_idle_cnt #(
    parameter int IDLE_TO = 8,
    parameter int IDLE_W  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic timeout
);
    logic [IDLE_W-1:0] cnt_q;

    assign timeout = run && (cnt_q == IDLE_W'(IDLE_TO - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || timeout)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + IDLE_W'(1);
    end
endmodule

// File: rtl/pgflash_rd_ctrl.sv
module pgflash_rd_ctrl
    import pgf_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 16,
    parameter int T_INIT  = 6,
    parameter int T_PAGE  = 2,
    parameter int IDLE_TO = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] fl_addr,
    input  logic [DATA_W-1:0] fl_dq,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n
);
    localparam int PG_W   = ADDR_W - WORD_SEL_W;
    localparam int CNT_W  = $clog2(T_INIT + 1);
    localparam int IDLE_W = $clog2(IDLE_TO + 1);

    rd_state_e         state_q;
    logic              ce_n_q, oe_n_q, vld_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    logic              accept, page_hit, wait_done, idle_expire;
    logic [CNT_W-1:0]  delay_val;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign delay_val = CNT_W'(access_cycles(page_hit, T_INIT, T_PAGE));

    pgf_page_track #(.PG_W(PG_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .req_page  (req_addr[ADDR_W-1:WORD_SEL_W]),
        .open_load (accept),
        .open_drop (idle_expire),
        .page_hit  (page_hit)
    );

    pgf_wait_cnt #(.CNT_W(CNT_W)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (delay_val),
        .expired  (wait_done)
    );

    pgf_idle_cnt #(.IDLE_TO(IDLE_TO), .IDLE_W(IDLE_W)) u_idle (
        .clk     (clk),
        .rst     (rst),
        .run     ((state_q == ST_IDLE) && !ce_n_q && !req_valid),
        .timeout (idle_expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ce_n_q  <= 1'b1;
            oe_n_q  <= 1'b1;
            vld_q   <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            vld_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        addr_q  <= req_addr;
                        ce_n_q  <= 1'b0;
                        oe_n_q  <= 1'b0;
                        state_q <= ST_WAIT;
                    end else if (idle_expire) begin
                        ce_n_q <= 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (wait_done) begin
                        data_q  <= fl_dq;
                        vld_q   <= 1'b1;
                        oe_n_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rd_valid  = vld_q;
    assign rd_data   = data_q;
    assign fl_addr   = addr_q;
    assign fl_ce_n   = ce_n_q;
    assign fl_oe_n   = oe_n_q;
    assign fl_we_n   = 1'b1;
endmodule

// File: rtl/pgf_rd_checker.sv
module pgf_rd_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] fl_addr,
    input logic              fl_ce_n,
    input logic              fl_oe_n,
    input logic              fl_we_n
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fl_ce_n && fl_oe_n && !rd_valid && req_ready));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    a_r2_result_after_wait: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (!$past(req_ready) && req_ready));

    a_r9_we_idle: assert property (@(posedge clk) disable iff (rst)
        fl_we_n);

    a_r9_oe_needs_ce: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> !fl_ce_n);

    a_r9_oe_in_wait: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> !fl_oe_n);

    a_r10_addr_hold: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> $stable(fl_addr));

    a_r5_ce_kept_after_read: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !fl_ce_n);
endmodule

bind pgflash_rd_ctrl pgf_rd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .fl_addr   (fl_addr),
    .fl_ce_n   (fl_ce_n),
    .fl_oe_n   (fl_oe_n),
    .fl_we_n   (fl_we_n)
);

// File: tb/sim_pgflash_rd_ctrl.sv
module sim_pgflash_rd_ctrl;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int TI = 6;
    localparam int TP = 2;
    localparam int TO = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready, rd_valid;
    logic [DW-1:0] rd_data, fl_dq;
    logic [AW-1:0] fl_addr;
    logic          fl_ce_n, fl_oe_n, fl_we_n;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    pgflash_rd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_INIT(TI), .T_PAGE(TP), .IDLE_TO(TO)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .fl_addr(fl_addr), .fl_dq(fl_dq), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
        .fl_we_n(fl_we_n)
    );

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return {a, ~a} ^ 16'h3C96;
    endfunction

    // flash model: correct data only once its timing has been met
    logic [AW-1:0] seen_addr = '0;
    int ce_age = 0, page_age = 0, addr_age = 0;
    always @(negedge clk) begin
        ce_age   <= fl_ce_n ? 0 : ce_age + 1;
        addr_age <= (fl_addr != seen_addr) ? 1 : addr_age + 1;
        page_age <= (fl_addr[AW-1:3] != seen_addr[AW-1:3]) ? 1 : page_age + 1;
        seen_addr <= fl_addr;
    end
    always_comb begin
        if (!fl_ce_n && !fl_oe_n && ce_age >= TI && page_age >= TI && addr_age >= TP)
            fl_dq = mem_word(fl_addr);
        else
            fl_dq = ~mem_word(fl_addr);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    bit            open_m = 1'b0;
    logic [AW-4:0] last_pg = '0;
    int            idle_extra = 0;

    task automatic do_read(input logic [AW-1:0] a, input int gap, input bit noise);
        bit hit, got;
        int lat, want;
        repeat (gap) @(negedge clk);
        hit = open_m && (a[AW-1:3] == last_pg) && ((gap + idle_extra) < TO);
        idle_extra = 0;
        chk(req_ready == 1'b1, "R8 ready when idle", int'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = a;
        lat = 0;
        got = 1'b0;
        while (!got && lat < 40) begin
            @(negedge clk);
            lat++;
            if (lat == 1) begin
                req_valid = noise;
                req_addr  = noise ? ~a : a;
            end
            if (rd_valid) begin
                got = 1'b1;
                req_valid = 1'b0;
            end else begin
                if (req_ready != 1'b0) chk(1'b0, "R8 busy during wait", int'(req_ready), 0);
                if (fl_addr != a) chk(1'b0, "R10 address held", int'(fl_addr), int'(a));
                if (fl_oe_n || fl_ce_n) chk(1'b0, "R9 enables in wait", int'({fl_ce_n, fl_oe_n}), 0);
            end
        end
        want = (hit ? TP : TI) + 1;
        if (hit) chk(lat == want, "R3 hit latency", lat, want);
        else     chk(lat == want, "R2 miss latency", lat, want);
        chk(rd_data == mem_word(a), "R7 read data", int'(rd_data), int'(mem_word(a)));
        chk(!fl_ce_n && fl_oe_n, "R5 ce held, oe off", int'({fl_ce_n, fl_oe_n}), 1);
        chk(fl_we_n == 1'b1, "R9 we high", int'(fl_we_n), 1);
        open_m  = 1'b1;
        last_pg = a[AW-1:3];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R2 watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(fl_ce_n && fl_oe_n && !rd_valid && req_ready, "R1 in reset",
            int'({fl_ce_n, fl_oe_n, rd_valid, req_ready}), 4'b1101);
        rst = 1'b0;
        @(negedge clk);
        chk(fl_ce_n && fl_oe_n && !rd_valid && req_ready, "R1 after reset",
            int'({fl_ce_n, fl_oe_n, rd_valid, req_ready}), 4'b1101);

        // R2 R3 R4: every word of one page ascending, first miss then hits
        for (int w = 0; w < 8; w++) do_read(AW'((5 << 3) | w), 0, 1'b0);
        // R7: single pulse
        @(negedge clk);
        idle_extra++;
        chk(rd_valid == 1'b0, "R7 pulse one cycle", int'(rd_valid), 0);
        // descending in another page
        for (int w = 7; w >= 0; w--) do_read(AW'((6 << 3) | w), 1, 1'b0);

        // R4: sweep pages and words, mixed orders and gaps
        for (int p = 0; p < 32; p++)
            for (int w = 0; w < 8; w++)
                do_read(AW'((p << 3) | ((w * 3 + p) & 7)), (p + w) % 3, 1'b0);
        // R4: alternate pages, high bit flips
        for (int i = 0; i < 16; i++)
            do_read(AW'(((i & 1) ? 8'h80 : 8'h00) | (i & 7)), 0, 1'b0);

        // R6: timeout boundary on both sides
        do_read(8'h48, 0, 1'b0);
        do_read(8'h4B, TO - 1, 1'b0);
        do_read(8'h4C, TO, 1'b0);
        // R6: chip enable drops exactly at IDLE_TO idle edges
        repeat (TO - 1) @(negedge clk);
        chk(fl_ce_n == 1'b0, "R6 ce before timeout", int'(fl_ce_n), 0);
        @(negedge clk);
        chk(fl_ce_n == 1'b1, "R6 ce released", int'(fl_ce_n), 1);
        idle_extra = TO;
        do_read(8'h4D, 0, 1'b0);

        // R8: requests during wait ignored
        do_read(8'h90, 0, 1'b1);
        do_read(8'h93, 0, 1'b1);
        do_read(8'hA1, 2, 1'b1);

        // R1: reset between reads forgets the open page
        do_read(8'h30, 0, 1'b0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(fl_ce_n == 1'b1, "R1 reset releases ce", int'(fl_ce_n), 1);
        open_m = 1'b0;
        do_read(8'h31, 0, 1'b0);
        do_read(8'h32, 0, 1'b0);

        summary();
        $finish;
    end
endmodule